// File: doc/BRIEF.md
# Serial ADC Read Sequencer

This block is the host-side controller for a three-wire serial sampling converter. On each request it raises a convert strobe, then drives a burst of serial clocks, shifts in the returned word and hands it over as a parallel sample. The serial clock is derived from the system clock through a programmable divider. The converter returns a word one frame late, so every sample belongs to the conversion launched by the previous frame. The sequencer tracks this and flags which results are real.

The same request port can put the converter into a light or a deep power-down. It does this by pulsing the strobe a set number of times while the serial clock stays low. The next run request first wakes the converter with a single serial clock pulse. After a deep power-down it also waits a programmable settling interval before it starts a conversion. The result width is 14 bits or 12 bits, selected by a parameter. In the 12-bit build the two trailing positions of the data window are dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset and whenever idle, `busy_o`, `done_o`, `sample_valid_o`, `smp_strobe_o` and `ser_clk_o` are all low.
- R2: A run frame (mode 2'b00) produces exactly 18 rising edges of `ser_clk_o` after the strobe rises. The last two of these follow the data window, so at least two serial clock periods separate the 16th rising edge from the next strobe.
- R3: The strobe rises HALF_DIV system cycles (half a serial clock period) before the first rising edge of the serial clock, and it stays high for exactly 2*HALF_DIV cycles.
- R4: `ser_data_i` is captured on rising serial clock edges 3 through 16 of a frame, with the first capture being the MSB. In the 14-bit build these 14 bits form `sample_o`.
- R5: In the 12-bit build, `sample_o` holds the captures from edges 3 through 14. The captures from edges 15 and 16 are discarded.
- R6: `sample_valid_o` rises together with `done_o` at the end of a run frame only when the previous operation was also a run frame. The first frame after reset is never valid, and neither is the first frame after a power-down.
- R7: A nap request (mode 2'b01) issues exactly 2 strobe pulses with `ser_clk_o` held low, and it produces no valid sample.
- R8: A sleep request (mode 2'b10) issues exactly 4 strobe pulses with `ser_clk_o` held low, and it produces no valid sample.
- R9: A run request made while powered down first gives one serial clock pulse. After a nap, the strobe rises HALF_DIV cycles after that pulse falls. After a sleep (including a sleep issued during a nap), the strobe rises HALF_DIV+SETTLE_CYC cycles after that pulse falls.
- R10: `start_i` and `mode_i` are ignored while `busy_o` is high. A start pulse given mid-frame does not alter the frame, does not launch a second operation, and does not power the converter down.
- R11: `busy_o` rises in the cycle after `start_i` is accepted. `done_o` is a one-cycle pulse, and `busy_o` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 2 | 00 run, 01 nap, 10 sleep, 11 treated as run |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| sample_o | output | RES_BITS | Last captured result |
| sample_valid_o | output | 1 | Result belongs to a real conversion |
| smp_strobe_o | output | 1 | Convert strobe to the converter |
| ser_clk_o | output | 1 | Serial clock to the converter |
| ser_data_i | input | 1 | Serial data from the converter |

## Verification
The assertions assume that `ser_data_i` is stable around each rising serial clock edge. They also assume that the requester holds `mode_i` valid in the cycle where `start_i` is accepted. The stimulus meets both assumptions. A behavioural converter model changes its data bit only on the falling serial clock edge or when the strobe rises. All request inputs are driven on the falling system clock edge. A mid-frame start pulse is driven on purpose, so that the busy-time filtering is exercised and not merely assumed.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_NAP   = 2'b01,
    PM_SLEEP = 2'b10,
    PM_RSVD  = 2'b11
  } pmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SETTLE,
    ST_FRAME,
    ST_PWR
  } seq_st_e;

  localparam int DATA_CLKS    = 16;
  localparam int ACQ_CLKS     = 2;
  localparam int CAP_FIRST    = 3;   // first rising edge carrying the MSB
  localparam int WORD_MAX     = 14;
  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;
endpackage

// File: rtl/adc_seq_tick.sv
module adc_seq_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + CW'(1);
  end

  p_tick_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= CW'(HALF_DIV - 1)));
endmodule

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int SETTLE_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic fin_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign fin_o = en_i && (cnt_q == CW'(SETTLE_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || fin_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + CW'(1);
  end

  p_settle_fin_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                bit_i,
  output logic [RES_BITS-1:0] word_o
);
  logic [WORD_MAX-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    shreg_q <= '0;
    else if (cap_i) shreg_q <= {shreg_q[WORD_MAX-2:0], bit_i};
  end

  // narrow builds keep the leading positions, trailing ones are don't-care
  generate
    if (RES_BITS < WORD_MAX) begin : g_trim
      assign word_o = shreg_q[WORD_MAX-1 -: RES_BITS];
    end else begin : g_full
      assign word_o = shreg_q;
    end
  endgenerate
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int HALF_DIV   = 2,
  parameter int SETTLE_CYC = 200000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [RES_BITS-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                smp_strobe_o,
  output logic                ser_clk_o,
  input  logic                ser_data_i
);
  localparam int FRAME_CLKS  = DATA_CLKS + ACQ_CLKS;
  localparam int FRAME_LAST  = 2 * FRAME_CLKS;          // slot 0 = strobe lead
  localparam int SW          = $clog2(FRAME_LAST + 1);
  localparam int CAP_LO      = 2 * (CAP_FIRST - 1);
  localparam int CAP_HI      = 2 * (CAP_FIRST + WORD_MAX - 2);
  localparam int NAP_LAST    = 2 * NAP_PULSES - 1;
  localparam int SLEEP_LAST  = 2 * SLEEP_PULSES - 1;

  seq_st_e state_q, state_d;
  logic [SW-1:0] slot_q, slot_d, pwr_last;
  pmode_e mode_q, req_mode;
  logic pd_q, deep_q, have_prev_q;
  logic conv_q, sck_q, done_q, valid_q;
  logic [RES_BITS-1:0] sample_q, word;
  logic tick, settle_fin, cap, frame_end, pwr_end, wake_exit;
  logic conv_d, sck_d;

  assign req_mode = pmode_e'(mode_i);
  assign pwr_last = (mode_q == PM_SLEEP) ? SW'(SLEEP_LAST) : SW'(NAP_LAST);

  adc_seq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .en_i  (state_q != ST_IDLE && state_q != ST_SETTLE),
    .tick_o(tick)
  );

  adc_seq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i (state_q == ST_SETTLE),
    .fin_o(settle_fin)
  );

  assign cap = (state_q == ST_FRAME) && tick && !slot_q[0] &&
               (slot_q >= SW'(CAP_LO)) && (slot_q <= SW'(CAP_HI));

  adc_seq_shift #(.RES_BITS(RES_BITS)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_i(cap), .bit_i(ser_data_i),
    .word_o(word)
  );

  assign frame_end = (state_q == ST_FRAME) && tick && (slot_q == SW'(FRAME_LAST));
  assign pwr_end   = (state_q == ST_PWR) && tick && (slot_q == pwr_last);
  assign wake_exit = (state_q == ST_WAKE) && tick && (slot_q == SW'(1));

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        slot_d = '0;
        if (req_mode == PM_NAP || req_mode == PM_SLEEP) state_d = ST_PWR;
        else if (pd_q)                                  state_d = ST_WAKE;
        else                                            state_d = ST_FRAME;
      end
      ST_WAKE: if (tick) begin
        if (wake_exit) begin
          slot_d  = '0;
          state_d = deep_q ? ST_SETTLE : ST_FRAME;
        end else slot_d = slot_q + SW'(1);
      end
      ST_SETTLE: if (settle_fin) begin
        slot_d  = '0;
        state_d = ST_FRAME;
      end
      ST_FRAME: if (tick) begin
        if (frame_end) state_d = ST_IDLE;
        else           slot_d  = slot_q + SW'(1);
      end
      ST_PWR: if (tick) begin
        if (pwr_end) state_d = ST_IDLE;
        else         slot_d  = slot_q + SW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // pin levels registered from the next slot so they change cleanly at slot start
  assign conv_d = (state_d == ST_FRAME && slot_d <= SW'(1)) ||
                  (state_d == ST_PWR && !slot_d[0]);
  assign sck_d  = (state_d == ST_FRAME && slot_d[0]) ||
                  (state_d == ST_WAKE && slot_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      slot_q      <= '0;
      mode_q      <= PM_RUN;
      pd_q        <= 1'b0;
      deep_q      <= 1'b0;
      have_prev_q <= 1'b0;
      conv_q      <= 1'b0;
      sck_q       <= 1'b0;
      done_q      <= 1'b0;
      valid_q     <= 1'b0;
      sample_q    <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      conv_q  <= conv_d;
      sck_q   <= sck_d;
      done_q  <= frame_end || pwr_end;
      valid_q <= frame_end && have_prev_q;
      if (state_q == ST_IDLE && start_i) mode_q <= req_mode;
      if (frame_end) begin
        sample_q    <= word;
        have_prev_q <= 1'b1;
      end
      if (pwr_end) begin
        pd_q        <= 1'b1;
        deep_q      <= deep_q || (mode_q == PM_SLEEP);
        have_prev_q <= 1'b0;
      end
      if (wake_exit) begin
        pd_q   <= 1'b0;
        deep_q <= 1'b0;
      end
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
  assign sample_valid_o = valid_q;
  assign sample_o       = sample_q;
  assign smp_strobe_o   = conv_q;
  assign ser_clk_o      = sck_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!smp_strobe_o && !ser_clk_o));
  p_frame_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME) |-> (slot_q <= SW'(FRAME_LAST)));
  p_strobe_lead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_strobe_o) |-> !ser_clk_o);
  p_valid_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> done_o);
  p_pwr_clk_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWR) |-> !ser_clk_o);
  p_settle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |-> (!smp_strobe_o && !ser_clk_o));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps

module adc_conv_model #(
  parameter int BITS = 14
) (
  input  logic        cnv,
  input  logic        sclk,
  input  logic [13:0] ain,
  output logic        sdo
);
  localparam logic [13:0] MASK = 14'((32'd1 << BITS) - 1);
  logic [13:0] held, word;
  int k;

  initial begin held = '0; word = '0; k = 0; sdo = 1'b1; end

  function automatic logic bit_at(int e);
    if (e >= 3 && e <= 2 + BITS) return word[BITS - 1 - (e - 3)];
    return 1'b1;
  endfunction

  always @(posedge cnv) begin
    word = held;
    held = ain & MASK;
    k = 0;
    sdo <= bit_at(1);
  end
  always @(posedge sclk) k = k + 1;
  always @(negedge sclk) sdo <= bit_at(k + 1);
endmodule

module adc_seq_ctrl_bench;
  localparam int HD = 2;
  localparam int ST = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [13:0] ain = '0;

  logic busy14, done14, valid14, conv14, sck14, sdo14;
  logic [13:0] sample14;
  logic busy12, done12, valid12, conv12, sck12, sdo12;
  logic [11:0] sample12;

  int checks = 0;
  int fails  = 0;
  bit last_run = 1'b0;
  logic [13:0] prev_val = '0;
  int pd = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl #(.RES_BITS(14), .HALF_DIV(HD), .SETTLE_CYC(ST)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .busy_o(busy14), .done_o(done14), .sample_o(sample14), .sample_valid_o(valid14),
    .smp_strobe_o(conv14), .ser_clk_o(sck14), .ser_data_i(sdo14));

  adc_seq_ctrl #(.RES_BITS(12), .HALF_DIV(HD), .SETTLE_CYC(ST)) u_adc_seq_ctrl_n12 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .busy_o(busy12), .done_o(done12), .sample_o(sample12), .sample_valid_o(valid12),
    .smp_strobe_o(conv12), .ser_clk_o(sck12), .ser_data_i(sdo12));

  adc_conv_model #(.BITS(14)) u_model14 (.cnv(conv14), .sclk(sck14), .ain(ain), .sdo(sdo14));
  adc_conv_model #(.BITS(12)) u_model12 (.cnv(conv12), .sclk(sck12), .ain(ain), .sdo(sdo12));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_op(input logic [1:0] m, input logic [13:0] v, input bit inject);
    int cyc = 0, n_conv = 0, n_rise = 0, rises_after = 0;
    int t_conv = 0, t_conv_fall = 0, t_first = 0, t_fall = 0, gap = 0;
    logic pc = 1'b0, ps = 1'b0;
    @(negedge clk);
    ain = v; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy14 == 1'b1, "R11", "busy after start", int'(busy14), 1);
    while (1) begin
      if (conv14 && !pc) begin n_conv++; t_conv = cyc; gap = cyc - t_fall; rises_after = 0; end
      if (!conv14 && pc) t_conv_fall = cyc;
      if (sck14 && !ps) begin n_rise++; rises_after++; if (rises_after == 1) t_first = cyc; end
      if (!sck14 && ps) t_fall = cyc;
      if (inject) begin
        if (cyc == 20) begin mode = 2'b10; start = 1'b1; end
        else if (cyc == 21) begin start = 1'b0; mode = 2'b00; end
      end
      if (done14) break;
      if (cyc > 3000) begin chk(1'b0, "R11", "done timeout", cyc, 0); break; end
      pc = conv14; ps = sck14; cyc++;
      @(negedge clk);
    end
    chk(done12 == 1'b1, "R11", "both widths finish together", int'(done12), 1);
    chk(busy14 == 1'b0, "R11", "busy low with done", int'(busy14), 0);
    if (m == 2'b00) begin
      chk(n_conv == 1, "R2", "strobes in frame", n_conv, 1);
      chk(rises_after == 18, "R2", "clock edges after strobe", rises_after, 18);
      chk(n_rise == 18 + ((pd != 0) ? 1 : 0), "R9", "total clock edges incl wake", n_rise,
          18 + ((pd != 0) ? 1 : 0));
      chk(t_first - t_conv == HD, "R3", "strobe lead", t_first - t_conv, HD);
      chk(t_conv_fall - t_conv == 2 * HD, "R3", "strobe width", t_conv_fall - t_conv, 2 * HD);
      if (pd == 2) chk(gap == HD + ST, "R9", "settle gap after sleep", gap, HD + ST);
      if (pd == 1) chk(gap == HD, "R9", "gap after nap", gap, HD);
      chk(valid14 == last_run, "R6", "valid 14b", int'(valid14), int'(last_run));
      chk(valid12 == last_run, "R6", "valid 12b", int'(valid12), int'(last_run));
      if (last_run) begin
        chk(sample14 == prev_val, "R4", "14b word", int'(sample14), int'(prev_val));
        chk(sample12 == prev_val[11:0], "R5", "12b word", int'(sample12), int'(prev_val[11:0]));
      end
      last_run = 1'b1; prev_val = v; pd = 0;
    end else begin
      if (m == 2'b01) chk(n_conv == 2, "R7", "nap strobes", n_conv, 2);
      else            chk(n_conv == 4, "R8", "sleep strobes", n_conv, 4);
      chk(n_rise == 0, "R7", "clock held during power command", n_rise, 0);
      chk(valid14 == 1'b0 && valid12 == 1'b0, "R8", "no valid on power command", int'(valid14), 0);
      last_run = 1'b0;
      pd = (m == 2'b10 || pd == 2) ? 2 : 1;
    end
    @(negedge clk);
    chk(done14 == 1'b0, "R11", "done one cycle", int'(done14), 0);
    chk(busy14 == 1'b0, "R10", "no extra operation launched", int'(busy14), 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL R11 watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy14 && !done14 && !valid14 && !conv14 && !sck14, "R1", "in reset", int'(busy14), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy14 && !done14 && !valid14 && !conv14 && !sck14, "R1", "idle after reset", int'(conv14), 0);
    chk(!busy12 && !conv12 && !sck12, "R1", "idle 12b", int'(busy12), 0);

    do_op(2'b00, 14'h1234, 1'b0);   // R6 first frame invalid
    do_op(2'b00, 14'h0000, 1'b0);
    do_op(2'b00, 14'h3FFF, 1'b0);
    do_op(2'b00, 14'h2AAA, 1'b0);
    do_op(2'b00, 14'h1555, 1'b0);
    do_op(2'b00, 14'h0001, 1'b0);
    do_op(2'b00, 14'h2000, 1'b0);
    for (int i = 0; i < 40; i++) do_op(2'b00, 14'((i * 977 + 13) % 16384), 1'b0);

    do_op(2'b01, 14'h0F0F, 1'b0);   // R7
    do_op(2'b00, 14'h0ABC, 1'b0);   // R9 wake without settle
    do_op(2'b00, 14'h3210, 1'b0);
    do_op(2'b10, 14'h0001, 1'b0);   // R8
    do_op(2'b00, 14'h1111, 1'b0);   // R9 settle
    do_op(2'b00, 14'h2222, 1'b0);
    do_op(2'b01, 14'h0000, 1'b0);
    do_op(2'b10, 14'h0000, 1'b0);   // sleep issued during nap
    do_op(2'b00, 14'h3333, 1'b0);
    do_op(2'b00, 14'h0444, 1'b0);

    do_op(2'b00, 14'h1A5A, 1'b1);   // R10 start mid-frame ignored
    do_op(2'b00, 14'h25A5, 1'b0);   // still valid: no power-down happened
    do_op(2'b00, 14'h0000, 1'b0);

    summary();
    $finish;
  end
endmodule